// File: doc/BRIEF.md
# Multiplexed DRAM Cycle Timing Sequencer

This block produces the strobes for one local memory cycle on a DRAM-style bus that shares its address pins between row and column. Three strobes are generated: a row strobe and a column strobe, both active low, and an address latch strobe. The block also drives the shared address lines and an upper byte lane. The upper lane carries the upper address byte while the row is out and the cycle status byte during the column phase. A ROM-enable line is driven alongside the row.

The clock runs at twice the sub-cycle rate. One tick is therefore half a sub-cycle, and every edge sits at a fixed tick of a 16-tick (eight sub-cycle) memory cycle. Ticks are numbered 0 to 15. Tick 0 is the first clock period after the edge that accepts a request. A requester raises `req` with the command fields valid. The request is taken only when the block is idle or is in tick 15, so cycles can run back to back with no gap. Read and write cycles share one strobe pattern and differ only in the status byte the requester supplies. A refresh cycle pulses the row strobe only.

Top module: `dmx_cycle_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the row strobe, the column strobe and the latch strobe are all high, and `mem_addr`, `mem_upper` and `mem_rom_en` are zero.
- R2: With no cycle running, all three strobes stay high and `mem_addr`, `mem_upper` and `mem_rom_en` are zero.
- R3: A cycle lasts exactly 16 ticks. A request is accepted only when the block is idle or at tick 15. A request raised during ticks 0 to 14 has no effect. A request present at tick 15 starts the next cycle with no idle tick between the two.
- R4: `mem_ras_n` is low in ticks 3 to 11 (9 ticks). It is high for the other 7 ticks of a cycle.
- R5: `mem_ale` is high in ticks 0 and 1 and low in ticks 2 to 15 of every cycle.
- R6: In ticks 0 to 4, `mem_addr` carries the row address, `mem_upper` carries the upper address byte and `mem_rom_en` carries the requested ROM enable. `mem_rom_en` is zero in ticks 5 to 15.
- R7: For a read or write cycle, `mem_addr` carries the column address in ticks 5 to 15. `mem_upper` carries the status byte in ticks 5 to 11 and is zero in ticks 12 to 15.
- R8: For a read or write cycle, `mem_cas_n` is low in ticks 6 to 11 (6 ticks) and high otherwise.
- R9: For a refresh cycle, `mem_cas_n` stays high for all 16 ticks. `mem_addr` holds the row address for all 16 ticks, and `mem_upper` is zero in ticks 5 to 15. The column strobe is never high for fewer than 4 ticks between two of its low pulses.
- R10: The `req_kind` encoding is: 2'b00 read, 2'b01 write, 2'b10 refresh. The value 2'b11 is treated as an access cycle, like read and write.
- R11: All command fields are captured when the request is accepted. Changing them during a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (half a sub-cycle per period) |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Cycle request |
| req_kind | input | 2 | Cycle type (see R10) |
| req_row | input | ADDR_W | Row address |
| req_col | input | ADDR_W | Column address |
| req_upper | input | UP_W | Upper address byte |
| req_stat | input | UP_W | Cycle status byte |
| req_rom_en | input | 1 | ROM enable for this cycle |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_ale | output | 1 | Address latch strobe |
| mem_addr | output | ADDR_W | Multiplexed row/column address |
| mem_upper | output | UP_W | Upper address byte or status byte |
| mem_rom_en | output | 1 | ROM enable |

## Verification
The bench builds the block with ADDR_W = 10 and UP_W = 8. At this address width, a row and column that differ only in their top two bits show whether the multiplexer switches the full lane, not just the lower byte. The bench uses row, column, upper and status values that all differ from one another, so any tick placed one position early or late shows up as a wrong value in a specific field. Its sequences cover every cycle kind, both orders of back-to-back access and refresh, and command fields that change in the middle of a cycle.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    // timing grid: ticks are half sub-cycles
    localparam int unsigned SUB_TICKS    = 2;
    localparam int unsigned SUBS_PER_CYC = 8;
    localparam int unsigned CYC_TICKS    = SUB_TICKS * SUBS_PER_CYC;
    localparam int unsigned PH_W         = $clog2(CYC_TICKS);

    typedef logic [PH_W-1:0] phase_t;

    localparam phase_t PH_LAST       = phase_t'(CYC_TICKS - 1);
    // latch strobe high for one sub-cycle from tick 0
    localparam phase_t PH_ALE_FALL   = phase_t'(SUB_TICKS);
    // row strobe falls 1.5 sub-cycles after the row is driven
    localparam phase_t PH_RAS_FALL   = phase_t'((3 * SUB_TICKS) / 2);
    // row strobe low for 4.5 sub-cycles
    localparam phase_t PH_RAS_RISE   = phase_t'(PH_RAS_FALL + (9 * SUB_TICKS) / 2);
    // column replaces row one sub-cycle after row strobe falls
    localparam phase_t PH_COL_SWITCH = phase_t'(PH_RAS_FALL + SUB_TICKS);
    // column strobe falls 1.5 sub-cycles after row strobe falls
    localparam phase_t PH_CAS_FALL   = phase_t'(PH_RAS_FALL + (3 * SUB_TICKS) / 2);

    // run lengths used by the strobe width checks
    localparam int unsigned RUN_W        = 5;
    typedef logic [RUN_W-1:0] run_t;
    localparam run_t RUN_MAX      = '1;
    localparam run_t RAS_LOW_LEN  = run_t'(PH_RAS_RISE - PH_RAS_FALL);
    localparam run_t RAS_HIGH_MIN = run_t'(CYC_TICKS - (PH_RAS_RISE - PH_RAS_FALL));
    localparam run_t CAS_LOW_LEN  = run_t'(PH_RAS_RISE - PH_CAS_FALL);
    localparam run_t CAS_HIGH_MIN = run_t'(2 * SUB_TICKS);

    typedef enum logic [1:0] {
        KIND_RD  = 2'b00,
        KIND_WR  = 2'b01,
        KIND_REF = 2'b10,
        KIND_RSV = 2'b11
    } kind_e;

endpackage

// File: rtl/dmx_phase_ctr.sv
module dmx_phase_ctr
    import dmx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    output logic   start,
    output logic   active_d,
    output phase_t phase_d
);

    typedef struct packed {
        logic   active;
        phase_t phase;
    } ctr_t;

    ctr_t st_d, st_q;
    logic open_q;

    always_comb begin
        st_d   = st_q;
        open_q = !st_q.active || (st_q.phase == PH_LAST);
        start  = req && open_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.phase  = '0;
        end else if (st_q.active && (st_q.phase != PH_LAST)) begin
            st_d.phase  = st_q.phase + phase_t'(1);
        end else begin
            st_d.active = 1'b0;
            st_d.phase  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_d = st_d.active;
    assign phase_d  = st_d.phase;

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && st_q.phase == PH_LAST && !req) |=> !st_q.active) // R3
        else $error("cycle ran past its last tick");

    AST_MID_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && st_q.phase != PH_LAST) |=> (st_q.active && st_q.phase == $past(st_q.phase) + phase_t'(1))) // R3
        else $error("cycle restarted before its last tick");

endmodule

// File: rtl/dmx_strobe_gen.sv
module dmx_strobe_gen
    import dmx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active_d,
    input  phase_t phase_d,
    input  logic   access_d,
    output logic   ras_n_q,
    output logic   cas_n_q,
    output logic   ale_q
);

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic ale;
    } strb_t;

    strb_t sd, sq;
    logic  in_ras, in_cas;

    always_comb begin
        in_ras   = (phase_d >= PH_RAS_FALL) && (phase_d < PH_RAS_RISE);
        in_cas   = (phase_d >= PH_CAS_FALL) && (phase_d < PH_RAS_RISE);
        sd.ras_n = !(active_d && in_ras);
        sd.cas_n = !(active_d && access_d && in_cas);
        sd.ale   = !active_d || (phase_d < PH_ALE_FALL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq <= '1;
        end else begin
            sq <= sd;
        end
    end

    assign ras_n_q = sq.ras_n;
    assign cas_n_q = sq.cas_n;
    assign ale_q   = sq.ale;

    // run-length counters for strobe width checks
    run_t ras_low_run, ras_high_run, cas_low_run, cas_high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_low_run  <= '0;
            ras_high_run <= RUN_MAX;
            cas_low_run  <= '0;
            cas_high_run <= RUN_MAX;
        end else begin
            if (sq.ras_n) begin
                ras_low_run  <= '0;
                ras_high_run <= (ras_high_run == RUN_MAX) ? RUN_MAX : ras_high_run + run_t'(1);
            end else begin
                ras_high_run <= '0;
                ras_low_run  <= (ras_low_run == RUN_MAX) ? RUN_MAX : ras_low_run + run_t'(1);
            end
            if (sq.cas_n) begin
                cas_low_run  <= '0;
                cas_high_run <= (cas_high_run == RUN_MAX) ? RUN_MAX : cas_high_run + run_t'(1);
            end else begin
                cas_high_run <= '0;
                cas_low_run  <= (cas_low_run == RUN_MAX) ? RUN_MAX : cas_low_run + run_t'(1);
            end
        end
    end

    AST_RAS_LOW_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(sq.ras_n) |-> (ras_low_run == RAS_LOW_LEN)) // R4
        else $error("row strobe low width wrong");

    AST_RAS_HIGH_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(sq.ras_n) |-> (ras_high_run >= RAS_HIGH_MIN)) // R4
        else $error("row strobe high width too short");

    AST_CAS_LOW_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(sq.cas_n) |-> (cas_low_run == CAS_LOW_LEN)) // R8
        else $error("column strobe low width wrong");

    AST_CAS_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(sq.cas_n) |-> (cas_high_run >= CAS_HIGH_MIN)) // R9
        else $error("column strobe high gap too short");

endmodule

// File: rtl/dmx_bus_mux.sv
module dmx_bus_mux
    import dmx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned UP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active_d,
    input  phase_t            phase_d,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [ADDR_W-1:0] req_col,
    input  logic [UP_W-1:0]   req_upper,
    input  logic [UP_W-1:0]   req_stat,
    input  logic              req_rom_en,
    output logic              access_d,
    output logic [ADDR_W-1:0] addr_q,
    output logic [UP_W-1:0]   upper_q,
    output logic              rom_q
);

    typedef struct packed {
        kind_e             kind;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [UP_W-1:0]   upper;
        logic [UP_W-1:0]   stat;
        logic              rom;
    } cmd_t;

    typedef struct packed {
        cmd_t              cmd;
        logic [ADDR_W-1:0] addr;
        logic [UP_W-1:0]   up;
        logic              rom;
    } mux_t;

    mux_t md, mq;
    logic in_row, in_stat;

    always_comb begin
        md = mq;
        if (start) begin
            md.cmd.kind  = kind_e'(req_kind);
            md.cmd.row   = req_row;
            md.cmd.col   = req_col;
            md.cmd.upper = req_upper;
            md.cmd.stat  = req_stat;
            md.cmd.rom   = req_rom_en;
        end
        access_d = (md.cmd.kind != KIND_REF);
        in_row   = (phase_d < PH_COL_SWITCH);
        in_stat  = (phase_d < PH_RAS_RISE);
        if (!active_d) begin
            md.addr = '0;
            md.up   = '0;
            md.rom  = 1'b0;
        end else begin
            md.addr = (in_row || !access_d) ? md.cmd.row : md.cmd.col;
            if (in_row) begin
                md.up = md.cmd.upper;
            end else if (access_d && in_stat) begin
                md.up = md.cmd.stat;
            end else begin
                md.up = '0;
            end
            md.rom = in_row ? md.cmd.rom : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mq <= '0;
        end else begin
            mq <= md;
        end
    end

    assign addr_q  = mq.addr;
    assign upper_q = mq.up;
    assign rom_q   = mq.rom;

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(mq.cmd)) // R11
        else $error("command changed without a new request");

endmodule

// File: rtl/dmx_cycle_seq.sv
module dmx_cycle_seq
    import dmx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned UP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [ADDR_W-1:0] req_col,
    input  logic [UP_W-1:0]   req_upper,
    input  logic [UP_W-1:0]   req_stat,
    input  logic              req_rom_en,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_ale,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [UP_W-1:0]   mem_upper,
    output logic              mem_rom_en
);

    logic   start, active_d, access_d;
    phase_t phase_d;

    dmx_phase_ctr i_phase (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .start    (start),
        .active_d (active_d),
        .phase_d  (phase_d)
    );

    dmx_bus_mux #(
        .ADDR_W (ADDR_W),
        .UP_W   (UP_W)
    ) i_mux (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .active_d   (active_d),
        .phase_d    (phase_d),
        .req_kind   (req_kind),
        .req_row    (req_row),
        .req_col    (req_col),
        .req_upper  (req_upper),
        .req_stat   (req_stat),
        .req_rom_en (req_rom_en),
        .access_d   (access_d),
        .addr_q     (mem_addr),
        .upper_q    (mem_upper),
        .rom_q      (mem_rom_en)
    );

    dmx_strobe_gen i_strobe (
        .clk      (clk),
        .rst      (rst),
        .active_d (active_d),
        .phase_d  (phase_d),
        .access_d (access_d),
        .ras_n_q  (mem_ras_n),
        .cas_n_q  (mem_cas_n),
        .ale_q    (mem_ale)
    );

    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
        !mem_cas_n |-> !mem_ras_n) // R8
        else $error("column strobe low outside row strobe");

    AST_ROW_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ras_n) |-> (mem_addr == $past(mem_addr, 3))) // R6
        else $error("row address not set up before row strobe");

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ras_n) |=> $stable(mem_addr)) // R6
        else $error("row address not held after row strobe");

    AST_COL_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cas_n) |-> ($stable(mem_addr) && $stable(mem_upper))) // R7
        else $error("column or status not set up before column strobe");

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ale) |=> ($stable(mem_addr) && $stable(mem_upper) && $stable(mem_rom_en))) // R6
        else $error("latched fields not held after latch strobe");

endmodule

// File: tb/test_dmx_cycle_seq.sv
module test_dmx_cycle_seq;

    localparam int AW = 10;
    localparam int UW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [AW-1:0] req_row = '0;
    logic [AW-1:0] req_col = '0;
    logic [UW-1:0] req_upper = '0;
    logic [UW-1:0] req_stat = '0;
    logic          req_rom_en = 1'b0;
    logic          mem_ras_n, mem_cas_n, mem_ale, mem_rom_en;
    logic [AW-1:0] mem_addr;
    logic [UW-1:0] mem_upper;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dmx_cycle_seq #(.ADDR_W(AW), .UP_W(UW)) i_dmx_cycle_seq (
        .clk(clk), .rst(rst), .req(req), .req_kind(req_kind),
        .req_row(req_row), .req_col(req_col), .req_upper(req_upper),
        .req_stat(req_stat), .req_rom_en(req_rom_en),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_ale(mem_ale),
        .mem_addr(mem_addr), .mem_upper(mem_upper), .mem_rom_en(mem_rom_en)
    );

    typedef struct {
        logic          ras_n, cas_n, ale, rom;
        logic [AW-1:0] addr;
        logic [UW-1:0] up;
        int            tick;
        logic          refr;
        logic          idle;
        string         scen;
    } exp_t;

    exp_t q[$];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic exp_t idle_item();
        exp_t e;
        e.ras_n = 1; e.cas_n = 1; e.ale = 1; e.rom = 0;
        e.addr = '0; e.up = '0; e.tick = -1; e.refr = 0; e.idle = 1; e.scen = "R2";
        return e;
    endfunction

    // expected pins per tick, from the requirements
    function automatic exp_t tick_item(input logic [1:0] k, input logic [AW-1:0] row, col,
                                       input logic [UW-1:0] up, st, input logic rom,
                                       input int t, input string scen);
        exp_t e;
        logic acc;
        acc     = (k != 2'b10);                      // R10
        e.ras_n = !(t >= 3 && t <= 11);              // R4
        e.cas_n = !(acc && t >= 6 && t <= 11);       // R8, R9
        e.ale   = (t < 2);                           // R5
        e.addr  = (t < 5 || !acc) ? row : col;       // R6, R7, R9
        e.up    = (t < 5) ? up : ((acc && t <= 11) ? st : '0);
        e.rom   = (t < 5) ? rom : 1'b0;
        e.tick = t; e.refr = !acc; e.idle = 0; e.scen = scen;
        return e;
    endfunction

    // driver: entered just after a falling edge, returns after tick 15 is shown
    task automatic issue(input logic [1:0] k, input logic [AW-1:0] row, col,
                         input logic [UW-1:0] up, st, input logic rom, input string scen);
        req = 1; req_kind = k; req_row = row; req_col = col;
        req_upper = up; req_stat = st; req_rom_en = rom;
        @(posedge clk); #1;
        for (int t = 0; t < 16; t++) q.push_back(tick_item(k, row, col, up, st, rom, t, scen));
        // R11 / R3: disturb fields and keep req high mid-cycle
        req_kind = k ^ 2'b10; req_row = ~row; req_col = ~col;
        req_upper = ~up; req_stat = ~st; req_rom_en = ~rom;
        repeat (14) @(posedge clk);
        #1 req = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 q.push_back(idle_item());
        end
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        exp_t e;
        string tg;
        if (!rst && q.size() > 0) begin
            e = q.pop_front();
            if (e.idle) begin
                chk("R2", "ras_n", 32'(mem_ras_n), 32'(e.ras_n));
                chk("R2", "cas_n", 32'(mem_cas_n), 32'(e.cas_n));
                chk("R2", "ale",   32'(mem_ale),   32'(e.ale));
                chk("R2", "addr",  32'(mem_addr),  32'(e.addr));
                chk("R2", "upper", 32'(mem_upper), 32'(e.up));
                chk("R2", "rom",   32'(mem_rom_en), 32'(e.rom));
            end else begin
                chk({"R4/", e.scen}, $sformatf("ras_n t%0d", e.tick), 32'(mem_ras_n), 32'(e.ras_n));
                chk({"R5/", e.scen}, $sformatf("ale t%0d", e.tick), 32'(mem_ale), 32'(e.ale));
                tg = e.refr ? "R9" : "R8";
                chk({tg, "/", e.scen}, $sformatf("cas_n t%0d", e.tick), 32'(mem_cas_n), 32'(e.cas_n));
                tg = (e.tick < 5) ? "R6" : (e.refr ? "R9" : "R7");
                chk({tg, "/", e.scen}, $sformatf("addr t%0d", e.tick), 32'(mem_addr), 32'(e.addr));
                chk({tg, "/", e.scen}, $sformatf("upper t%0d", e.tick), 32'(mem_upper), 32'(e.up));
                chk({"R6/", e.scen}, $sformatf("rom t%0d", e.tick), 32'(mem_rom_en), 32'(e.rom));
            end
        end
    end

    task automatic reset_check();
        chk("R1", "ras_n", 32'(mem_ras_n), 32'd1);
        chk("R1", "cas_n", 32'(mem_cas_n), 32'd1);
        chk("R1", "ale",   32'(mem_ale),   32'd1);
        chk("R1", "addr",  32'(mem_addr),  32'd0);
        chk("R1", "upper", 32'(mem_upper), 32'd0);
        chk("R1", "rom",   32'(mem_rom_en), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        reset_check();                         // R1 during reset
        rst = 0;
        @(posedge clk);
        @(negedge clk);
        reset_check();                         // R1 first cycle after
        idle(3);                               // R2
        issue(2'b00, 10'h2A5, 10'h15A, 8'hC3, 8'h81, 1'b1, "R7");   // read
        idle(2);
        issue(2'b01, 10'h0F0, 10'h30F, 8'h5A, 8'h42, 1'b0, "R10");  // write
        issue(2'b10, 10'h1E3, 10'h21C, 8'h96, 8'h77, 1'b1, "R9");   // refresh right after write (R3)
        issue(2'b11, 10'h3C1, 10'h03E, 8'h69, 8'hE4, 1'b1, "R10");  // reserved code acts as access
        issue(2'b10, 10'h111, 10'h2EE, 8'h0F, 8'hF0, 1'b0, "R3");   // back-to-back refresh
        issue(2'b00, 10'h200, 10'h1FF, 8'hA5, 8'h3C, 1'b1, "R11");  // read after refresh
        idle(4);
        wait (q.size() == 0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule